// File: doc/BRIEF.md
# Power-of-Two Shift Divider

This block scales a W-bit operand by a power of two chosen at run time. In divide mode it shifts the operand right by k places. In multiply mode it shifts the operand left by k places. A mode bit chooses whether the operand is read as an unsigned number or as a two's-complement number.

For signed division the quotient must round toward zero. A plain arithmetic shift would round negative operands toward minus infinity. To prevent that, the block adds 2^k-1 to a negative dividend before it shifts. The sum is formed one bit wider than the operand, so the most negative value cannot wrap.

Multiply keeps only the low W bits of the shifted value. It also raises a flag when the true product does not fit in W bits, judged by the signed or the unsigned rule as the mode selects. One register stage with a valid/ready pair on each side holds the result until it is taken.

Top module: `pow2_shift_divider`

## Requirements
- R1: While reset is low, and on the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: With in_op=0 (divide) and in_signed=0, out_result is the operand divided by 2^k, with the vacated high bits filled with zeros.
- R3: With in_op=0 and in_signed=1, out_result is the two's-complement quotient of operand/2^k rounded toward zero. A negative operand whose low k bits are nonzero gives one more than the arithmetic-shift result. A negative operand whose low k bits are zero gives exactly the arithmetic-shift result.
- R4: A shift amount of k=0 returns the operand unchanged for both operations and both interpretations.
- R5: The most negative signed operand (only the top bit set) divides correctly for every k, with no wrap in the bias addition.
- R6: With in_op=1 (multiply), out_result is the low W bits of the operand times 2^k, and these bits do not depend on in_signed.
- R7: With in_op=1 and in_signed=0, out_mul_ovf is 1 exactly when the unsigned product exceeds 2^W-1.
- R8: With in_op=1 and in_signed=1, out_mul_ovf is 1 exactly when the signed product lies outside -2^(W-1) to 2^(W-1)-1.
- R9: With in_op=0, out_mul_ovf is 0.
- R10: An input is accepted on a rising edge where in_valid and in_ready are both 1. Its result appears with out_valid=1 right after the next rising edge.
- R11: While out_valid=1 and out_ready=0, out_result, out_mul_ovf and out_valid hold their values. During that time in_ready is 0, so a new input is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid |
| in_ready | output | 1 | Block can take an input this cycle |
| in_operand | input | W | Value to be scaled |
| in_shift | input | $clog2(W) | Power k of the divisor or multiplier |
| in_signed | input | 1 | 1 = two's complement, 0 = unsigned |
| in_op | input | 1 | 0 = divide by 2^k, 1 = multiply by 2^k |
| out_valid | output | 1 | Result register holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | W | Quotient or truncated product |
| out_mul_ovf | output | 1 | Multiply lost significant bits |

## Verification
Every result and its overflow flag are due on the rising edge that follows the accepting edge. The bench drives each vector on a falling edge and lets exactly one rising edge pass. It then samples out_valid, out_result and out_mul_ovf on the next falling edge, half a cycle after they change. In the stall test, out_ready is held low for several cycles, and the held values and in_ready are sampled on each falling edge while the stall lasts.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;
  typedef enum logic {
    OP_DIV = 1'b0,
    OP_MUL = 1'b1
  } scale_op_e;
endpackage

// File: rtl/pdiv_shift_right.sv
module pdiv_shift_right #(
  parameter int W  = 16,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [KW-1:0] k,
  input  logic          is_signed,
  output logic [W-1:0]  quotient,
  output logic          bias_used
);
  // Quotient rounded toward zero; the bias sum is one bit wider than the operand.
  function automatic logic [W-1:0] scale_down(input logic [W-1:0] a,
                                              input logic [KW-1:0] sh,
                                              input logic sgn);
    logic        [W:0] bias;
    logic signed [W:0] ext;
    logic signed [W:0] sum;
    ext  = sgn ? $signed({a[W-1], a}) : $signed({1'b0, a});
    bias = (sgn && a[W-1]) ? (((W+1)'(1) << sh) - (W+1)'(1)) : '0;
    sum  = ext + $signed(bias);
    return W'(sum >>> sh);
  endfunction

  assign quotient  = scale_down(operand, k, is_signed);
  assign bias_used = is_signed & operand[W-1] & (k != '0);
endmodule

// File: rtl/pdiv_shift_left.sv
module pdiv_shift_left #(
  parameter int W  = 16,
  parameter int KW = $clog2(W)
) (
  input  logic [W-1:0]  operand,
  input  logic [KW-1:0] k,
  input  logic          is_signed,
  output logic [W-1:0]  product,
  output logic          lost_bits
);
  function automatic logic [2*W-1:0] widen_shift(input logic [W-1:0] a,
                                                 input logic [KW-1:0] sh,
                                                 input logic sgn);
    logic [2*W-1:0] ext;
    ext = sgn ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
    return ext << sh;
  endfunction

  // Unsigned: any bit above the word. Signed: upper bits plus sign not uniform.
  function automatic logic overflowed(input logic [2*W-1:0] full, input logic sgn);
    logic [W:0] top;
    top = full[2*W-1:W-1];
    if (sgn) return !((&top) || (~|top));
    return |full[2*W-1:W];
  endfunction

  logic [2*W-1:0] wide;

  assign wide      = widen_shift(operand, k, is_signed);
  assign product   = wide[W-1:0];
  assign lost_bits = overflowed(wide, is_signed);
endmodule

// File: rtl/pdiv_out_reg.sv
module pdiv_out_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] d_result,
  input  logic         d_ovf,
  input  logic         d_mul,
  output logic         q_valid,
  output logic [W-1:0] q_result,
  output logic         q_ovf,
  output logic         q_mul
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_ovf    <= 1'b0;
      q_mul    <= 1'b0;
    end else if (load) begin
      q_valid  <= 1'b1;
      q_result <= d_result;
      q_ovf    <= d_ovf;
      q_mul    <= d_mul;
    end else if (take) begin
      q_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/pow2_shift_divider.sv
module pow2_shift_divider
  import pow2_div_pkg::*;
#(
  parameter int W = 16,
  localparam int KW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_operand,
  input  logic [KW-1:0] in_shift,
  input  logic          in_signed,
  input  logic          in_op,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_result,
  output logic          out_mul_ovf
);
  scale_op_e    op_sel;
  logic [W-1:0] div_q;
  logic         div_biased;
  logic [W-1:0] mul_p;
  logic         mul_lost;
  logic         accept;
  logic [W-1:0] next_result;
  logic         next_ovf;
  logic         op_mul_q;

  assign op_sel   = scale_op_e'(in_op);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  pdiv_shift_right #(.W(W), .KW(KW)) u_right (
    .operand   (in_operand),
    .k         (in_shift),
    .is_signed (in_signed),
    .quotient  (div_q),
    .bias_used (div_biased)
  );

  pdiv_shift_left #(.W(W), .KW(KW)) u_left (
    .operand   (in_operand),
    .k         (in_shift),
    .is_signed (in_signed),
    .product   (mul_p),
    .lost_bits (mul_lost)
  );

  always_comb begin
    if (op_sel == OP_MUL) begin
      next_result = mul_p;
      next_ovf    = mul_lost;
    end else begin
      next_result = div_q;
      next_ovf    = 1'b0;
    end
  end

  pdiv_out_reg #(.W(W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .take     (out_ready),
    .d_result (next_result),
    .d_ovf    (next_ovf),
    .d_mul    (op_sel == OP_MUL),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_ovf    (out_mul_ovf),
    .q_mul    (op_mul_q)
  );
endmodule

// File: rtl/pow2_shift_divider_chk.sv
module pow2_shift_divider_chk #(
  parameter int W  = 16,
  parameter int KW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [W-1:0]  in_operand,
  input logic [KW-1:0] in_shift,
  input logic          in_signed,
  input logic          in_op,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  out_result,
  input logic          out_mul_ovf,
  input logic          op_mul_q,
  input logic          div_biased
);
  assert_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_mul_ovf)));

  assert_k_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_shift == '0) |=> (out_result == $past(in_operand) && !out_mul_ovf));

  assert_unsigned_div_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_op && !in_signed) |=> (out_result <= $past(in_operand)));

  assert_div_no_ovf_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !op_mul_q) |-> !out_mul_ovf);

  // R3: a biased negative division never produces a positive quotient
  assert_bias_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_op && div_biased) |=> out_result[W-1] || out_result == '0);
endmodule

bind pow2_shift_divider pow2_shift_divider_chk #(.W(W), .KW(KW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_operand  (in_operand),
  .in_shift    (in_shift),
  .in_signed   (in_signed),
  .in_op       (in_op),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_mul_ovf (out_mul_ovf),
  .op_mul_q    (op_mul_q),
  .div_biased  (div_biased)
);

// File: tb/tb_pow2_shift_divider.sv
module tb_pow2_shift_divider;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int KW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  in_operand;
  logic [KW-1:0] in_shift;
  logic          in_signed;
  logic          in_op;
  logic          out_valid;
  logic          out_ready;
  logic [W-1:0]  out_result;
  logic          out_mul_ovf;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pow2_shift_divider #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_shift(in_shift), .in_signed(in_signed),
    .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_mul_ovf(out_mul_ovf)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (op=%0d sgn=%0d k=%0d a=%0d)",
               tag, act, exp, in_op, in_signed, in_shift, in_operand);
    end
  endtask

  // Drive one vector with out_ready high; its result is sampled one cycle later.
  task automatic run_vector(input int op, input int sgn, input int k, input int a);
    longint av, scale, q, p;
    longint exp_res, exp_ovf;
    string  rtag, otag;
    av    = (sgn != 0 && a >= 128) ? longint'(a) - 256 : longint'(a);
    scale = longint'(1) << k;
    if (op == 0) begin
      q       = av / scale;          // truncating division rounds toward zero
      exp_res = q & 255;
      exp_ovf = 0;
      otag    = "R9";
      rtag    = (sgn == 0) ? "R2" : ((a == 128) ? "R5" : "R3");
    end else begin
      p       = av * scale;
      exp_res = p & 255;
      if (sgn != 0) exp_ovf = (p > 127 || p < -128) ? 1 : 0;
      else          exp_ovf = (p > 255) ? 1 : 0;
      otag    = (sgn != 0) ? "R8" : "R7";
      rtag    = "R6";
    end
    if (k == 0) rtag = "R4";
    in_op      = op[0];
    in_signed  = sgn[0];
    in_shift   = KW'(k);
    in_operand = W'(a);
    in_valid   = 1'b1;
    out_ready  = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 out_valid", longint'(out_valid), 1);
    check(rtag, longint'(out_result), exp_res);
    check(otag, longint'(out_mul_ovf), exp_ovf);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_operand = '0; in_shift = '0; in_signed = 1'b0; in_op = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 out_valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", longint'(out_valid), 0);
    check("R1 in_ready after reset", longint'(in_ready), 1);

    for (int op = 0; op < 2; op++)
      for (int sgn = 0; sgn < 2; sgn++)
        for (int k = 0; k < W; k++)
          for (int a = 0; a < 256; a++)
            run_vector(op, sgn, k, a);

    // R11: stall the output and offer a competing input
    @(negedge clk);
    in_op = 1'b0; in_signed = 1'b0; in_shift = 3'd2; in_operand = 8'd200;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 stall load valid", longint'(out_valid), 1);
    check("R11 stall load result", longint'(out_result), 50);
    in_operand = 8'd7; in_shift = 3'd0; in_valid = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R11 held valid", longint'(out_valid), 1);
      check("R11 held result", longint'(out_result), 50);
      check("R11 in_ready low", longint'(in_ready), 0);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R11 drained", longint'(out_valid), 0);
    check("R11 ready again", longint'(in_ready), 1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule